// File: doc/BRIEF.md
# Poll-Triggered Conversion Word Sender

This block sits between a free-running data converter and a host serial line. The converter has no start input. It posts a fresh 16-bit result, together with a one-cycle strobe, at a fixed interval. The block forwards a result only when the host asks for one. A receiver on the serial input listens for a byte whose eight data bits are all zero. When that byte arrives, the receiver raises a request flag.

While the flag is up, the next conversion strobe captures the result. In asynchronous mode the captured word goes out on the transmit line as two framed bytes. In synchronous mode the block instead shifts the word into an external 16-bit serial-to-parallel register, which is two cascaded 8-bit stages, and then issues a single load pulse. A two-bit tap select picks the bit period from a binary divider of the system clock. Each poll yields exactly one word.

Top module: `polled_word_tx`

## Requirements
- R1: After reset, `txd` is high and `armed`, `sclk` and `sload` are low.
- R2: A byte on `rxd` with start bit 0, eight data bits all 0 and stop bit 1 raises `armed` when the block is idle.
- R3: A received byte with any data bit set, or with a stop bit of 0, is discarded: `armed` stays low and no word is sent.
- R4: The word sent is `conv_word` at the first `conv_valid` strobe after `armed` rises, and it is unchanged for the whole send.
- R5: In asynchronous mode (`sync_mode`=0) the word leaves `txd` as two frames sent back to back, bits [15:8] first and then bits [7:0]. Each frame is a 0 start bit, eight data bits LSB first and a 1 stop bit. Every bit lasts 2^(2+`tap_sel`) clock cycles.
- R6: In asynchronous mode `armed` stays high through the first frame and drops when the start bit of the second frame begins.
- R7: A valid poll that arrives while a word is being sent is ignored: no second word follows, and `armed` stays low after the send.
- R8: In synchronous mode (`sync_mode`=1) `sclk` pulses high for one cycle exactly 16 times, one pulse every 2^(2+`tap_sel`) cycles. `sdo` carries bit 15 first and bit 0 last, and is valid while `sclk` is high. `sload` is high for the one cycle after the last pulse, and `txd` stays high throughout.
- R9: In synchronous mode `armed` stays high while shifting and is low from the load cycle on.
- R10: Without a poll, conversion strobes cause no activity on `txd`, `sclk` or `sload`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tap_sel | input | TAP_W | Divider tap; bit period is 2^(DIV_MIN+tap_sel) cycles |
| sync_mode | input | 1 | 0: two UART frames on txd, 1: synchronous shift out |
| conv_valid | input | 1 | One-cycle strobe marking a fresh conversion result |
| conv_word | input | 16 | Conversion result, valid with conv_valid |
| rxd | input | 1 | Serial poll input, idle high |
| txd | output | 1 | Serial data output, idle high |
| armed | output | 1 | Request flag |
| sclk | output | 1 | Shift clock pulse for the external register |
| sdo | output | 1 | Shift data for the external register |
| sload | output | 1 | Parallel load strobe for the external register |

## Verification
The main function is swept over every tap setting in both output modes. Each run polls once and then sends a second null byte in the middle of the send. A wrong bit period therefore corrupts the decoded frames, and a failure to ignore the second poll shows up as an extra word in the quiet window that follows. The conversion value changes with every strobe, so capturing the wrong strobe, or letting the held word drift, produces a mismatch. Null bytes with a bad stop bit and non-zero bytes are sent first, to show that only a clean null frame arms the block.

// File: rtl/polled_word_tx.sv
module polled_word_tx #(
  parameter int DIV_MIN = 2,
  parameter int TAP_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAP_W-1:0] tap_sel,
  input  logic             sync_mode,
  input  logic             conv_valid,
  input  logic [15:0]      conv_word,
  input  logic             rxd,
  output logic             txd,
  output logic             armed,
  output logic             sclk,
  output logic             sdo,
  output logic             sload
);
  localparam int CW = DIV_MIN + (1 << TAP_W) - 1;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_SEND, S_LOAD} st_t;
  st_t st;

  logic [CW-1:0] mask, bcnt, rcnt;
  logic [15:0]   word;
  logic          mode_r;
  logic [4:0]    idx;
  logic [2:0]    rxq;
  logic          rx_on;
  logic [3:0]    ridx;
  logic [7:0]    rsh;
  logic [19:0]   frame;
  logic          bit_end, rx_smp, rxi, rx_poll, last_bit;

  assign mask     = CW'((64'd1 << (DIV_MIN + 32'(tap_sel))) - 64'd1);
  assign bit_end  = (bcnt & mask) == mask;
  assign rxi      = rxq[1];
  assign rx_smp   = rx_on && ((rcnt & mask) == (mask >> 1));
  assign rx_poll  = rx_smp && ridx == 4'd9 && rxi && rsh == 8'd0;
  assign frame    = {1'b1, word[7:0], 1'b0, 1'b1, word[15:8], 1'b0};
  assign last_bit = mode_r ? (idx == 5'd15) : (idx == 5'd19);

  assign txd   = (st == S_SEND && !mode_r) ? frame[idx] : 1'b1;
  assign sclk  = st == S_SEND && mode_r && bit_end;
  assign sdo   = st == S_SEND && mode_r && word[4'd15 - idx[3:0]];
  assign sload = st == S_LOAD;
  assign armed = st == S_ARMED || (st == S_SEND && (mode_r || idx < 5'd10));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxq   <= 3'b111;
      rx_on <= 1'b0;
      ridx  <= '0;
      rsh   <= '0;
      rcnt  <= '0;
    end else begin
      rxq <= {rxq[1:0], rxd};
      if (!rx_on) begin
        if (rxq[2] && !rxq[1]) begin
          rx_on <= 1'b1;
          ridx  <= '0;
          rcnt  <= '0;
        end
      end else begin
        rcnt <= rcnt + 1'b1;
        if (rx_smp) begin
          ridx <= ridx + 4'd1;
          if (ridx == 4'd0) begin
            if (rxi) rx_on <= 1'b0;
          end else if (ridx == 4'd9) begin
            rx_on <= 1'b0;
          end else begin
            rsh <= {rxi, rsh[7:1]};
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      word   <= '0;
      mode_r <= 1'b0;
      idx    <= '0;
      bcnt   <= '0;
    end else begin
      case (st)
        S_IDLE:  if (rx_poll) st <= S_ARMED;
        S_ARMED: if (conv_valid) begin
          word   <= conv_word;
          mode_r <= sync_mode;
          idx    <= '0;
          bcnt   <= '0;
          st     <= S_SEND;
        end
        S_SEND: begin
          bcnt <= bcnt + 1'b1;
          if (bit_end) begin
            if (last_bit) st <= mode_r ? S_LOAD : S_IDLE;
            else idx <= idx + 5'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && $past(st == S_SEND)) |-> $stable(word));

  // R8
  load_follows_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sload |-> $past(sclk));

  // R8
  line_quiet_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && mode_r) |-> txd);

  // R6
  flag_drop_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(armed) && !mode_r) |-> (st == S_SEND && idx == 5'd10));

  // R7
  busy_poll_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && rx_poll) |=> st != S_ARMED);

  // R2
  idle_poll_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && rx_poll) |=> armed);

  // R8
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk && sload));
endmodule

// File: tb/polled_word_tx_bench.sv
module polled_word_tx_bench;
  localparam int CONV_INT = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] tap_sel = 2'd0;
  logic sync_mode = 1'b0;
  logic conv_valid = 1'b0;
  logic [15:0] conv_word = 16'h0;
  logic rxd = 1'b1;
  logic txd, armed, sclk, sdo, sload;

  int n_chk = 0;
  int n_bad = 0;
  int p = 4;
  bit cap_done = 1'b0;
  logic [15:0] expw = 16'h0;

  always #10 clk = ~clk;

  polled_word_tx u_polled_word_tx (
    .clk(clk), .rst_n(rst_n), .tap_sel(tap_sel), .sync_mode(sync_mode),
    .conv_valid(conv_valid), .conv_word(conv_word), .rxd(rxd),
    .txd(txd), .armed(armed), .sclk(sclk), .sdo(sdo), .sload(sload));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    int k = 0;
    forever begin
      repeat (CONV_INT - 1) @(posedge clk);
      #1 conv_valid = 1'b1;
      conv_word = 16'(k * 40503) ^ 16'hA55A;
      @(posedge clk);
      #1 conv_valid = 1'b0;
      k++;
    end
  end

  always @(negedge clk) begin
    if (!armed) cap_done = 1'b0;
    else if (conv_valid && !cap_done) begin
      cap_done = 1'b1;
      expw = conv_word;
    end
  end

  task automatic send_byte(input logic [7:0] b, input logic stopv, input int per);
    logic [9:0] bits;
    bits = {stopv, b, 1'b0};
    @(posedge clk);
    #1;
    for (int i = 0; i < 10; i++) begin
      rxd = bits[i];
      repeat (per) @(posedge clk);
      #1;
    end
    rxd = 1'b1;
  endtask

  task automatic quiet(input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || sclk !== 1'b0 || sload !== 1'b0 || armed !== 1'b0) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic uart_decode(input int per);
    logic [19:0] bits;
    int guard = 0;
    bit a_mid1 = 1'b0, a_start2 = 1'b1;
    bits = '0;
    do begin @(negedge clk); guard++; end while (txd !== 1'b0 && guard < 4000);
    check(guard < 4000, "R5 start seen", guard, 0);
    for (int i = 0; i < 20; i++) begin
      repeat ((i == 0) ? per / 2 : per) @(negedge clk);
      bits[i] = txd;
      if (i == 9) a_mid1 = armed;
      if (i == 10) a_start2 = armed;
    end
    check(bits[0] == 1'b0 && bits[9] == 1'b1, "R5 frame1 start/stop", {bits[9], bits[0]}, 2'b10);
    check(bits[10] == 1'b0 && bits[19] == 1'b1, "R5 frame2 start/stop", {bits[19], bits[10]}, 2'b10);
    check({bits[8:1], bits[18:11]} == expw, "R5 R4 word", {bits[8:1], bits[18:11]}, expw);
    check(a_mid1 == 1'b1, "R6 armed in frame1", a_mid1, 1);
    check(a_start2 == 1'b0, "R6 armed cleared at frame2", a_start2, 0);
  endtask

  task automatic sync_collect();
    logic [15:0] sr = '0;
    int n = 0, guard = 0, txbad = 0, ldbad = 0;
    bit a_shift = 1'b0;
    while (n < 16 && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (txd !== 1'b1) txbad++;
      if (sload !== 1'b0) ldbad++;
      if (sclk === 1'b1) begin
        sr = {sr[14:0], sdo};
        n++;
        if (n == 1) a_shift = armed;
      end
    end
    check(n == 16, "R8 pulse count", n, 16);
    check(txbad == 0 && ldbad == 0, "R8 txd high, no early load", txbad + ldbad, 0);
    check(a_shift == 1'b1, "R9 armed while shifting", a_shift, 1);
    @(negedge clk);
    check(sload == 1'b1, "R8 load strobe", sload, 1);
    check(armed == 1'b0, "R9 armed low at load", armed, 0);
    check(sr == expw, "R8 R4 shifted word", sr, expw);
    @(negedge clk);
    check(sload == 1'b0, "R8 load one cycle", sload, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(txd == 1'b1 && armed == 1'b0 && sclk == 1'b0 && sload == 1'b0,
          "R1 reset state", {txd, armed, sclk, sload}, 4'b1000);
    #1 rst_n = 1'b1;

    quiet(1500, "R10 no poll no output");

    p = 4;
    send_byte(8'h00, 1'b0, p);
    repeat (3 * p) @(negedge clk);
    check(armed == 1'b0, "R3 bad stop", armed, 0);
    send_byte(8'h01, 1'b1, p);
    repeat (3 * p) @(negedge clk);
    check(armed == 1'b0, "R3 data 01", armed, 0);
    send_byte(8'h80, 1'b1, p);
    repeat (3 * p) @(negedge clk);
    check(armed == 1'b0, "R3 data 80", armed, 0);
    quiet(1200, "R3 no word after rejected bytes");

    for (int m = 0; m < 2; m++) begin
      for (int t = 0; t < 4; t++) begin
        tap_sel = 2'(t);
        sync_mode = m[0];
        p = 1 << (2 + t);
        send_byte(8'h00, 1'b1, p);
        repeat (4) @(negedge clk);
        check(armed == 1'b1, "R2 null byte arms", armed, 1);
        fork
          begin
            if (m == 0) uart_decode(p);
            else sync_collect();
          end
          begin
            wait (cap_done == 1'b1);
            repeat (2 * p) @(posedge clk);
            send_byte(8'h00, 1'b1, p);
          end
        join
        repeat (2) @(negedge clk);
        quiet(CONV_INT + 200 + 20 * p, "R7 poll during send ignored");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule